// File: doc/BRIEF.md
# Pipelined Loop Counter Unit

This unit keeps the 64-bit loop status word of a processor that runs software-pipelined loops. The word holds three counters and two flag bits. The counters are a loop count, an epilogue count and a prologue count. The flag bits are a count-valid marker and a sticky overflow marker. Software loads the whole word and reads it back. A bundle may ask the unit to step its counters, and it does so with a 2-bit advance code that is qualified by the bundle's branch condition.

The counters step in a fixed chain. The prologue count goes first, then the loop count. The epilogue count moves only once the loop count has reached zero. From the value held at the start of the cycle, the unit derives four flags:

- prologue active
- epilogue active
- last iteration
- loop end

The branch logic uses these flags. When the bundle header marks loop mode, the unit also blocks array stores, together with their address auto-increment, while the prologue is still running.

Top module: `loop_ctl_unit`

## Requirements
- R1: After a synchronous reset, the status word is all zeros and all four flags are low.
- R2: A write loads all 64 bits, and `rd_data` always returns the held word. A write wins over an advance requested in the same cycle.
- R3: The advance code decides whether the counters step:
  - 0: never.
  - 1: only when `br_cond` is 0.
  - 2: only when `br_cond` is 1.
  - 3: always.
- R4: On an advance, the prologue count (bits 52:48) and the loop count (bits 31:0) each drop by one and stay at zero once there.
- R5: On an advance, if the loop count after its step is zero, overflow bit 38 is set. The bit stays set until software writes the word.
- R6: The epilogue count (bits 36:32) drops by one, stopping at zero, only on an advance whose resulting loop count is zero.
- R7: An advance leaves every other bit unchanged, including count-valid bit 37 and bits 39 and 40.
- R8: `last_iter` is high exactly when the loop count is below 2 and bit 37 is set.
- R9: `loop_end` is high exactly when the epilogue count is zero and `last_iter` is high.
- R10: Loop mode is bit 10 of `bundle_hdr`.
  - In loop mode, `prologue` equals (prologue count != 0) and `epilogue` equals (loop count == 0).
  - Outside loop mode, both flags are low.
- R11: For each store lane, `st_go` and `st_inc` follow `st_req`, except in loop mode with a nonzero prologue count, when both are 0.
- R12: All flags reflect the word held before any advance applied in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Word to load |
| rd_data | output | 64 | Current status word |
| adv_code | input | 2 | Advance condition code |
| br_cond | input | 1 | Branch condition of the bundle |
| bundle_hdr | input | 16 | Bundle header; bit 10 selects loop mode |
| st_req | input | 2 | Array store request per lane |
| st_go | output | 2 | Store allowed per lane |
| st_inc | output | 2 | Address auto-increment allowed per lane |
| prologue | output | 1 | Prologue active |
| epilogue | output | 1 | Epilogue active |
| last_iter | output | 1 | Last iteration |
| loop_end | output | 1 | Loop end |

## Verification
The clocked assertions assume that `wr_en`, `adv_code` and `br_cond` are never unknown once reset has been released. They also assume that `bundle_hdr` and `st_req` are driven to known values whenever the gating outputs are sampled. The bench sets every input to a defined value at time zero, before reset ends. It changes inputs only a moment after a rising edge, so each step sees a single settled bundle. Each loaded word is picked to cross a zero boundary of the chain.

// File: rtl/loop_ctl_pkg.sv
package loop_ctl_pkg;

    localparam int LSR_W        = 64;
    localparam int LC_LO        = 0;
    localparam int LC_W         = 32;
    localparam int EC_LO        = 32;
    localparam int EC_W         = 5;
    localparam int PC_LO        = 48;
    localparam int PC_W         = 5;
    localparam int VLD_BIT      = 37;
    localparam int OVF_BIT      = 38;
    localparam int HDR_LOOP_BIT = 10;

    typedef enum logic [1:0] {
        ADV_NEVER    = 2'd0,
        ADV_ON_FALSE = 2'd1,
        ADV_ON_TRUE  = 2'd2,
        ADV_ALWAYS   = 2'd3
    } adv_code_e;

    typedef struct packed {
        logic [PC_W-1:0] pcnt;
        logic [EC_W-1:0] ecnt;
        logic [LC_W-1:0] lcnt;
        logic            vld;
        logic            ovf;
    } cnt_view_t;

    function automatic cnt_view_t view_of(input logic [LSR_W-1:0] w);
        cnt_view_t v;
        v.pcnt = w[PC_LO +: PC_W];
        v.ecnt = w[EC_LO +: EC_W];
        v.lcnt = w[LC_LO +: LC_W];
        v.vld  = w[VLD_BIT];
        v.ovf  = w[OVF_BIT];
        return v;
    endfunction

    function automatic logic adv_taken(input adv_code_e c, input logic cond);
        case (c)
            ADV_ON_FALSE: return !cond;
            ADV_ON_TRUE:  return cond;
            ADV_ALWAYS:   return 1'b1;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/loop_adv_step.sv
module loop_adv_step
    import loop_ctl_pkg::*;
(
    input  logic [LSR_W-1:0] cur,
    input  adv_code_e        code,
    input  logic             cond,
    output logic [LSR_W-1:0] nxt
);
    cnt_view_t       v;
    logic [LC_W-1:0] lc_n;
    logic [PC_W-1:0] pc_n;
    logic [EC_W-1:0] ec_n;
    logic            lc_out;

    always_comb begin
        v      = view_of(cur);
        pc_n   = (v.pcnt == '0) ? '0 : v.pcnt - 1'b1;
        lc_n   = (v.lcnt == '0) ? '0 : v.lcnt - 1'b1;
        lc_out = (lc_n == '0);
        ec_n   = v.ecnt;
        if (lc_out && v.ecnt != '0)
            ec_n = v.ecnt - 1'b1;
        nxt = cur;
        if (adv_taken(code, cond)) begin
            nxt[PC_LO +: PC_W] = pc_n;
            nxt[LC_LO +: LC_W] = lc_n;
            nxt[EC_LO +: EC_W] = ec_n;
            if (lc_out)
                nxt[OVF_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/loop_flag_gen.sv
module loop_flag_gen
    import loop_ctl_pkg::*;
(
    input  logic [LSR_W-1:0] cur,
    input  logic             loop_mode,
    output logic             prologue,
    output logic             epilogue,
    output logic             last_iter,
    output logic             loop_end
);
    cnt_view_t v;

    always_comb begin
        v         = view_of(cur);
        last_iter = (v.lcnt < LC_W'(2)) && v.vld;
        loop_end  = (v.ecnt == '0) && last_iter;
        prologue  = loop_mode && (v.pcnt != '0);
        epilogue  = loop_mode && (v.lcnt == '0);
    end
endmodule

// File: rtl/loop_store_gate.sv
module loop_store_gate #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] req,
    input  logic             block,
    output logic [LANES-1:0] go,
    output logic [LANES-1:0] inc
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign go[i]  = req[i] && !block;
        assign inc[i] = req[i] && !block;
    end
endmodule

// File: rtl/loop_ctl_unit.sv
module loop_ctl_unit
    import loop_ctl_pkg::*;
#(
    parameter int HDR_W    = 16,
    parameter int ST_LANES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [LSR_W-1:0]    wr_data,
    output logic [LSR_W-1:0]    rd_data,
    input  logic [1:0]          adv_code,
    input  logic                br_cond,
    input  logic [HDR_W-1:0]    bundle_hdr,
    input  logic [ST_LANES-1:0] st_req,
    output logic [ST_LANES-1:0] st_go,
    output logic [ST_LANES-1:0] st_inc,
    output logic                prologue,
    output logic                epilogue,
    output logic                last_iter,
    output logic                loop_end
);
    logic [LSR_W-1:0] lsr_q;
    logic [LSR_W-1:0] lsr_adv;
    logic             loop_mode;

    assign loop_mode = bundle_hdr[HDR_LOOP_BIT];
    assign rd_data   = lsr_q;

    loop_adv_step u_step (
        .cur  (lsr_q),
        .code (adv_code_e'(adv_code)),
        .cond (br_cond),
        .nxt  (lsr_adv)
    );

    loop_flag_gen u_flags (
        .cur       (lsr_q),
        .loop_mode (loop_mode),
        .prologue  (prologue),
        .epilogue  (epilogue),
        .last_iter (last_iter),
        .loop_end  (loop_end)
    );

    loop_store_gate #(.LANES(ST_LANES)) u_gate (
        .req   (st_req),
        .block (prologue),
        .go    (st_go),
        .inc   (st_inc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            lsr_q <= '0;
        else if (wr_en)
            lsr_q <= wr_data;
        else
            lsr_q <= lsr_adv;
    end

    // R2
    wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (lsr_q == $past(wr_data)));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (lsr_q[OVF_BIT] && !wr_en) |=> lsr_q[OVF_BIT]);

    // R4
    pcnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (lsr_q[PC_LO +: PC_W] <= $past(lsr_q[PC_LO +: PC_W])));

    // R6
    ecnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && lsr_q[LC_LO +: LC_W] > LC_W'(1)) |=> $stable(lsr_q[EC_LO +: EC_W]));

    // R7
    vld_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(lsr_q[VLD_BIT]));

    // R9
    loop_end_chk: assert property (@(posedge clk) disable iff (rst)
        loop_end |-> last_iter);

    // R11
    st_block_chk: assert property (@(posedge clk) disable iff (rst)
        prologue |-> (st_go == '0 && st_inc == '0));
endmodule

// File: tb/sim_loop_ctl_unit.sv
module sim_loop_ctl_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic [1:0]  adv_code = 2'd0;
    logic        br_cond = 1'b0;
    logic [15:0] bundle_hdr = '0;
    logic [1:0]  st_req = '0;
    logic [1:0]  st_go, st_inc;
    logic        prologue, epilogue, last_iter, loop_end;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    loop_ctl_unit u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .adv_code(adv_code), .br_cond(br_cond), .bundle_hdr(bundle_hdr),
        .st_req(st_req), .st_go(st_go), .st_inc(st_inc),
        .prologue(prologue), .epilogue(epilogue),
        .last_iter(last_iter), .loop_end(loop_end)
    );

    function automatic logic [63:0] mk(input int pc, input int ec, input logic [31:0] lc,
                                      input logic vld, input logic ovf, input logic hi2);
        logic [63:0] w;
        w = '0;
        w[52:48] = 5'(pc);
        w[36:32] = 5'(ec);
        w[31:0]  = lc;
        w[37]    = vld;
        w[38]    = ovf;
        w[39]    = hi2;
        w[40]    = hi2;
        return w;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic load(input logic [63:0] w);
        wr_en = 1'b1; wr_data = w;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [1:0] c, input logic b);
        adv_code = c; br_cond = b;
        @(posedge clk); #1;
        adv_code = 2'd0;
    endtask

    task automatic t_reset;
        chk("R1 word", rd_data, 64'd0);
        chk("R1 flags", {60'd0, prologue, epilogue, last_iter, loop_end}, 64'd0);
    endtask

    task automatic t_write;
        load(64'hDEAD_BEEF_0123_4567);
        chk("R2 readback", rd_data, 64'hDEAD_BEEF_0123_4567);
        wr_en = 1'b1; wr_data = mk(0, 0, 4, 0, 0, 0); adv_code = 2'd3;
        @(posedge clk); #1;
        wr_en = 1'b0; adv_code = 2'd0;
        chk("R2 write beats advance", rd_data, mk(0, 0, 4, 0, 0, 0));
    endtask

    task automatic t_codes;
        load(mk(0, 0, 10, 0, 0, 0));
        step(2'd0, 1'b1); chk("R3 code0", rd_data, mk(0, 0, 10, 0, 0, 0));
        step(2'd1, 1'b1); chk("R3 code1 cond1", rd_data, mk(0, 0, 10, 0, 0, 0));
        step(2'd1, 1'b0); chk("R3 code1 cond0", rd_data, mk(0, 0, 9, 0, 0, 0));
        step(2'd2, 1'b0); chk("R3 code2 cond0", rd_data, mk(0, 0, 9, 0, 0, 0));
        step(2'd2, 1'b1); chk("R3 code2 cond1", rd_data, mk(0, 0, 8, 0, 0, 0));
        step(2'd3, 1'b0); chk("R3 code3", rd_data, mk(0, 0, 7, 0, 0, 0));
    endtask

    task automatic t_chain;
        load(mk(2, 2, 2, 1, 0, 1));
        chk("R8 lcnt2 not last", {63'd0, last_iter}, 64'd0);
        step(2'd3, 1'b0);
        chk("R4 R7 first step", rd_data, mk(1, 2, 1, 1, 0, 1));
        chk("R8 last at lcnt1", {63'd0, last_iter}, 64'd1);
        chk("R9 no end ecnt2", {63'd0, loop_end}, 64'd0);
        step(2'd3, 1'b0);
        chk("R5 R6 lcnt hits zero", rd_data, mk(0, 1, 0, 1, 1, 1));
        step(2'd3, 1'b0);
        chk("R6 ecnt to zero", rd_data, mk(0, 0, 0, 1, 1, 1));
        chk("R9 loop end", {63'd0, loop_end}, 64'd1);
        step(2'd3, 1'b0);
        chk("R4 R6 saturate", rd_data, mk(0, 0, 0, 1, 1, 1));
        step(2'd0, 1'b0);
        chk("R5 sticky", rd_data, mk(0, 0, 0, 1, 1, 1));
        load(mk(0, 0, 5, 1, 0, 0));
        chk("R5 cleared by write", rd_data, mk(0, 0, 5, 1, 0, 0));
    endtask

    task automatic t_last;
        load(mk(0, 0, 1, 0, 0, 0));
        chk("R8 no valid", {63'd0, last_iter}, 64'd0);
        load(mk(0, 3, 0, 1, 0, 0));
        chk("R8 lcnt0 valid", {63'd0, last_iter}, 64'd1);
        chk("R9 ecnt nonzero", {63'd0, loop_end}, 64'd0);
    endtask

    task automatic t_modes;
        load(mk(1, 0, 0, 0, 0, 0));
        st_req = 2'b11; bundle_hdr = 16'h0000; #1;
        chk("R10 mode off flags", {62'd0, prologue, epilogue}, 64'd0);
        chk("R11 mode off stores", {60'd0, st_go, st_inc}, 64'hF);
        bundle_hdr = 16'h0200; #1;
        chk("R10 bit9 not mode", {62'd0, prologue, epilogue}, 64'd0);
        bundle_hdr = 16'h0400; #1;
        chk("R10 mode on flags", {62'd0, prologue, epilogue}, 64'd3);
        chk("R11 prologue blocks", {60'd0, st_go, st_inc}, 64'd0);
        st_req = 2'b01;
        // R12: flags are read from the word held before an advance lands
        adv_code = 2'd3; #1;
        chk("R12 pre-advance prologue", {63'd0, prologue}, 64'd1);
        @(posedge clk); #1;
        adv_code = 2'd0;
        chk("R11 after prologue", {60'd0, st_go, st_inc}, 64'b0101);
        bundle_hdr = '0; st_req = '0;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_write();
        t_codes();
        t_chain();
        t_last();
        t_modes();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule